// File: doc/BRIEF.md
# Delay-Line Contention Slot Scheduler

This block is the electronic control for an optical packet switch that avoids output collisions by sending packets through fiber delay lines of different lengths. Time is divided into slots of one packet each. In every slot up to `N_PORTS` packets arrive, each with a valid bit and a destination port. The scheduler puts each packet on one of `N_LINES` delay lines, where line *i* holds it for exactly *i* slots. No two packets that leave in the same future slot may share a destination. It keeps one mask of committed destinations for each future exit slot. The masks shift by one entry per slot, and the entry for the slot that is now exiting is released.

When a new packet finds no legal delay line, it goes onto one of `N_RECIRC` one-slot recirculation lines. It comes back in the next slot and is scheduled ahead of all new arrivals. If the packet fails again when it comes back, or if no recirculation line is free, it is dropped. A saturating counter totals every drop. All decisions for a slot appear on the outputs one clock after the requests are sampled.

Top module: `slot_sched`

## Requirements
- R1: While reset is held low and on the first clock after it is released, every grant, recirculation, drop and line field reads zero and `drop_count` is zero. No destination is committed in any future slot.
- R2: A granted packet receives the smallest delay that is legal. The line field carries the delay in slots (1 to `N_LINES`), and the value 0 means no line was granted.
- R3: In one slot, no delay line is granted to more than one packet, counting both arrivals and returning packets.
- R4: A packet is never placed so that it exits in the same slot as a packet already committed, in this slot or an earlier one, to the same destination.
- R5: Requests are served in a fixed order: returning packets by recirculation index, then new arrivals by ascending input index. Each one sees the lines and exit slots taken by those served before it.
- R6: A valid new arrival that finds no legal delay line is sent to the lowest-numbered recirculation line still free in that slot, and its `gnt_recirc` bit is set.
- R7: A recirculated packet is presented again in the next slot, ahead of arrivals, with its original destination. Its outcome appears on `rc_line`/`rc_drop` at the index of the recirculation line it used. If it again finds no legal line, it is dropped.
- R8: A valid new arrival that finds neither a legal delay line nor a free recirculation line has its `gnt_drop` bit set.
- R9: `drop_count` increases each slot by the number of drop bits set in that slot (across `gnt_drop` and `rc_drop`). It never decreases and holds at its all-ones maximum.
- R10: The outputs for a slot reflect the requests sampled at the previous rising clock edge. An input whose request was not valid shows zero line, no recirculation and no drop.
- R11: Every valid request and every returning packet has exactly one outcome in its slot: a line, a recirculation, or a drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one packet slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_PORTS | Per-input packet present in this slot |
| req_dest | input | N_PORTS*DW | Per-input destination, input p at bits [p*DW +: DW] |
| gnt_line | output | N_PORTS*LW | Per-input granted delay (0 = none), input p at [p*LW +: LW] |
| gnt_recirc | output | N_PORTS | Per-input packet sent to a recirculation line |
| gnt_drop | output | N_PORTS | Per-input packet dropped |
| rc_line | output | N_RECIRC*LW | Granted delay for the packet returning on each recirculation line |
| rc_drop | output | N_RECIRC | Returning packet dropped |
| drop_count | output | CNT_W | Saturating total of dropped packets |

## Verification
A stale or corrupted entry in the committed-destination masks shows at the ports within `N_LINES` slots. The next packet for that destination receives a longer or shorter delay than the exit-slot arithmetic allows, or is sent to recirculation when a line was free. A lost recirculated packet shows one slot later as a recirculation grant with no outcome on `rc_line`/`rc_drop`. A miscounted drop shows in `drop_count` in the same cycle as the drop bits. The bench models exit slots on an absolute time axis instead of a shifting array, so a shift that is off by one disagrees with it within a few slots.

// File: rtl/slot_sched_pkg.sv
`timescale 1ns/1ps
package slot_sched_pkg;

    // Population count of up to 64 flags.
    function automatic int unsigned flag_count(input logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/slot_sched_stage.sv
`timescale 1ns/1ps
// One link of the priority chain: picks the shortest legal delay line for
// one request and passes on the updated line usage and exit-slot masks.
module slot_sched_stage #(
    parameter int N_PORTS = 4,
    parameter int N_LINES = 4,
    parameter int DW      = 2,
    parameter int LW      = 3
) (
    input  logic                         vld,
    input  logic [DW-1:0]                dest,
    input  logic [N_LINES*N_PORTS-1:0]   occ_in,
    input  logic [N_LINES-1:0]           used_in,
    output logic                         found,
    output logic [LW-1:0]                line,
    output logic [N_LINES*N_PORTS-1:0]   occ_out,
    output logic [N_LINES-1:0]           used_out
);
    always_comb begin
        found    = 1'b0;
        line     = '0;
        occ_out  = occ_in;
        used_out = used_in;
        for (int i = 0; i < N_LINES; i++) begin
            if (vld && !found && !used_in[i] &&
                !occ_in[i*N_PORTS + int'(dest)]) begin
                found                              = 1'b1;
                line                               = LW'(i + 1);
                used_out[i]                        = 1'b1;
                occ_out[i*N_PORTS + int'(dest)]    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/slot_sched_recirc.sv
`timescale 1ns/1ps
// Hands failed new arrivals to recirculation lines in input order;
// the overflow is dropped.
module slot_sched_recirc #(
    parameter int N_PORTS  = 4,
    parameter int N_RECIRC = 2,
    parameter int DW       = 2
) (
    input  logic [N_PORTS-1:0]     fail,
    input  logic [N_PORTS*DW-1:0]  dest,
    output logic [N_PORTS-1:0]     to_rc,
    output logic [N_PORTS-1:0]     to_drop,
    output logic [N_RECIRC-1:0]    rc_vld_n,
    output logic [N_RECIRC*DW-1:0] rc_dest_n
);
    always_comb begin
        int unsigned slot;
        slot      = 0;
        to_rc     = '0;
        to_drop   = '0;
        rc_vld_n  = '0;
        rc_dest_n = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            if (fail[p]) begin
                if (slot < N_RECIRC) begin
                    to_rc[p]                   = 1'b1;
                    rc_vld_n[slot]             = 1'b1;
                    rc_dest_n[slot*DW +: DW]   = dest[p*DW +: DW];
                    slot                       = slot + 1;
                end else begin
                    to_drop[p] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/slot_sched.sv
`timescale 1ns/1ps
module slot_sched #(
    parameter int N_PORTS  = 4,
    parameter int N_LINES  = 4,
    parameter int N_RECIRC = 2,
    parameter int CNT_W    = 8,
    localparam int DW      = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
    localparam int LW      = $clog2(N_LINES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_PORTS-1:0]       req_valid,
    input  logic [N_PORTS*DW-1:0]    req_dest,
    output logic [N_PORTS*LW-1:0]    gnt_line,
    output logic [N_PORTS-1:0]       gnt_recirc,
    output logic [N_PORTS-1:0]       gnt_drop,
    output logic [N_RECIRC*LW-1:0]   rc_line,
    output logic [N_RECIRC-1:0]      rc_drop,
    output logic [CNT_W-1:0]         drop_count
);
    import slot_sched_pkg::*;

    localparam int NQ   = N_RECIRC + N_PORTS;   // chain length
    localparam int OCCW = N_LINES * N_PORTS;

    typedef struct packed {
        logic [OCCW-1:0]          occ;      // exit-slot masks, entry k = delay k+1
        logic [N_RECIRC-1:0]      rc_vld;
        logic [N_RECIRC*DW-1:0]   rc_dest;
        logic [N_PORTS*LW-1:0]    g_line;
        logic [N_PORTS-1:0]       g_rec;
        logic [N_PORTS-1:0]       g_drop;
        logic [N_RECIRC*LW-1:0]   r_line;
        logic [N_RECIRC-1:0]      r_drop;
        logic [CNT_W-1:0]         cnt;
    } state_t;

    state_t st_d, st_q;

    // Priority chain: returning packets first, then arrivals.
    logic [NQ-1:0]      q_vld;
    logic [NQ*DW-1:0]   q_dest;
    logic [NQ-1:0]      q_found;
    logic [NQ*LW-1:0]   q_line;
    logic [OCCW-1:0]    occ_c  [NQ+1];
    logic [N_LINES-1:0] used_c [NQ+1];

    assign q_vld     = {req_valid, st_q.rc_vld};
    assign q_dest    = {req_dest, st_q.rc_dest};
    assign occ_c[0]  = st_q.occ;
    assign used_c[0] = '0;

    for (genvar k = 0; k < NQ; k++) begin : g_chain
        slot_sched_stage #(
            .N_PORTS (N_PORTS),
            .N_LINES (N_LINES),
            .DW      (DW),
            .LW      (LW)
        ) u_stage (
            .vld      (q_vld[k]),
            .dest     (q_dest[k*DW +: DW]),
            .occ_in   (occ_c[k]),
            .used_in  (used_c[k]),
            .found    (q_found[k]),
            .line     (q_line[k*LW +: LW]),
            .occ_out  (occ_c[k+1]),
            .used_out (used_c[k+1])
        );
    end

    logic [N_PORTS-1:0]     in_fail;
    logic [N_PORTS-1:0]     in_to_rc;
    logic [N_PORTS-1:0]     in_to_drop;
    logic [N_RECIRC-1:0]    rc_vld_n;
    logic [N_RECIRC*DW-1:0] rc_dest_n;

    assign in_fail = req_valid & ~q_found[NQ-1:N_RECIRC];

    slot_sched_recirc #(
        .N_PORTS  (N_PORTS),
        .N_RECIRC (N_RECIRC),
        .DW       (DW)
    ) u_recirc (
        .fail      (in_fail),
        .dest      (req_dest),
        .to_rc     (in_to_rc),
        .to_drop   (in_to_drop),
        .rc_vld_n  (rc_vld_n),
        .rc_dest_n (rc_dest_n)
    );

    always_comb begin
        logic [63:0]      drop_flags;
        logic [CNT_W:0]   sum;
        int unsigned      ndrop;

        st_d = st_q;

        for (int p = 0; p < N_PORTS; p++) begin
            st_d.g_line[p*LW +: LW] = q_line[(N_RECIRC+p)*LW +: LW];
        end
        for (int r = 0; r < N_RECIRC; r++) begin
            st_d.r_line[r*LW +: LW] = q_line[r*LW +: LW];
            st_d.r_drop[r]          = st_q.rc_vld[r] & ~q_found[r];
        end
        st_d.g_rec   = in_to_rc;
        st_d.g_drop  = in_to_drop;
        st_d.rc_vld  = rc_vld_n;
        st_d.rc_dest = rc_dest_n;

        // Advance the exit-slot record; delay-1 entry is released.
        for (int k = 0; k < N_LINES - 1; k++) begin
            st_d.occ[k*N_PORTS +: N_PORTS] = occ_c[NQ][(k+1)*N_PORTS +: N_PORTS];
        end
        st_d.occ[(N_LINES-1)*N_PORTS +: N_PORTS] = '0;

        drop_flags = '0;
        drop_flags[N_PORTS-1:0] = st_d.g_drop;
        drop_flags[N_PORTS +: N_RECIRC] = st_d.r_drop;
        ndrop = flag_count(drop_flags);
        sum   = {1'b0, st_q.cnt} + (CNT_W+1)'(ndrop);
        st_d.cnt = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_line   = st_q.g_line;
    assign gnt_recirc = st_q.g_rec;
    assign gnt_drop   = st_q.g_drop;
    assign rc_line    = st_q.r_line;
    assign rc_drop    = st_q.r_drop;
    assign drop_count = st_q.cnt;

endmodule

// File: rtl/slot_sched_chk.sv
`timescale 1ns/1ps
module slot_sched_chk #(
    parameter int N_PORTS  = 4,
    parameter int N_LINES  = 4,
    parameter int N_RECIRC = 2,
    parameter int CNT_W    = 8,
    parameter int LW       = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_PORTS-1:0]     req_valid,
    input logic [N_PORTS*LW-1:0]  gnt_line,
    input logic [N_PORTS-1:0]     gnt_recirc,
    input logic [N_PORTS-1:0]     gnt_drop,
    input logic [N_RECIRC*LW-1:0] rc_line,
    input logic [N_RECIRC-1:0]    rc_drop,
    input logic [CNT_W-1:0]       drop_count
);
    localparam int NQ = N_PORTS + N_RECIRC;

    // Per delay line: which granted packets sit on it this slot.
    for (genvar i = 1; i <= N_LINES; i++) begin : g_line_use
        logic [NQ-1:0] hit;
        always_comb begin
            for (int p = 0; p < N_PORTS; p++)
                hit[p] = (int'(gnt_line[p*LW +: LW]) == i);
            for (int r = 0; r < N_RECIRC; r++)
                hit[N_PORTS+r] = (int'(rc_line[r*LW +: LW]) == i);
        end
        // R3
        line_single_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(hit));
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        logic has_line;
        assign has_line = (gnt_line[p*LW +: LW] != '0);
        // R11
        one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(req_valid[p]) |->
            $countones({has_line, gnt_recirc[p], gnt_drop[p]}) == 1);
        // R10
        idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && !$past(req_valid[p]) |->
            !has_line && !gnt_recirc[p] && !gnt_drop[p]);
    end

    // R7
    recirc_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_recirc) |=> ((|rc_drop) || (rc_line != '0)));

    // R9
    count_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> drop_count >= $past(drop_count));

    // R9
    count_needs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (drop_count != $past(drop_count)) |->
        ((|gnt_drop) || (|rc_drop)));

endmodule

bind slot_sched slot_sched_chk #(
    .N_PORTS  (N_PORTS),
    .N_LINES  (N_LINES),
    .N_RECIRC (N_RECIRC),
    .CNT_W    (CNT_W),
    .LW       (LW)
) u_slot_sched_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .gnt_line   (gnt_line),
    .gnt_recirc (gnt_recirc),
    .gnt_drop   (gnt_drop),
    .rc_line    (rc_line),
    .rc_drop    (rc_drop),
    .drop_count (drop_count)
);

// File: tb/slot_sched_test.sv
`timescale 1ns/1ps
module slot_sched_test;
    localparam int N  = 4;
    localparam int S  = 4;
    localparam int R  = 2;
    localparam int CW = 8;
    localparam int DW = 2;
    localparam int LW = 3;
    localparam int TM = 32;   // exit-slot table, larger than S+1

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [N*DW-1:0] req_dest = '0;
    logic [N*LW-1:0] gnt_line;
    logic [N-1:0]    gnt_recirc, gnt_drop;
    logic [R*LW-1:0] rc_line;
    logic [R-1:0]    rc_drop;
    logic [CW-1:0]   drop_count;

    always #2 clk = ~clk;   // 4 ns period

    slot_sched #(.N_PORTS(N), .N_LINES(S), .N_RECIRC(R), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
        .gnt_line(gnt_line), .gnt_recirc(gnt_recirc), .gnt_drop(gnt_drop),
        .rc_line(rc_line), .rc_drop(rc_drop), .drop_count(drop_count));

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Reference model on an absolute time axis.
    bit exitmap [TM][N];
    int t_now;
    bit m_rv [R];
    int m_rd [R];
    int e_line [N];
    bit e_rec [N];
    bit e_drop [N];
    int e_rcl [R];
    bit e_rcd [R];
    int e_cnt;

    task automatic model_reset();
        for (int a = 0; a < TM; a++) for (int d = 0; d < N; d++) exitmap[a][d] = 0;
        for (int r = 0; r < R; r++) begin m_rv[r] = 0; m_rd[r] = 0; end
        t_now = 0;
        e_cnt = 0;
    endtask

    function automatic int try_place(int d, ref bit used [S+1]);
        for (int i = 1; i <= S; i++) begin
            if (!used[i] && !exitmap[(t_now + i) % TM][d]) begin
                used[i] = 1;
                exitmap[(t_now + i) % TM][d] = 1;
                return i;
            end
        end
        return 0;
    endfunction

    task automatic model_slot(input logic [N-1:0] v, input logic [N*DW-1:0] dv);
        bit used [S+1];
        bit nrv [R];
        int nrd [R];
        int nr, drops;
        for (int i = 0; i <= S; i++) used[i] = 0;
        for (int r = 0; r < R; r++) begin nrv[r] = 0; nrd[r] = 0; end
        nr = 0; drops = 0;
        for (int r = 0; r < R; r++) begin
            e_rcl[r] = 0; e_rcd[r] = 0;
            if (m_rv[r]) begin
                e_rcl[r] = try_place(m_rd[r], used);
                if (e_rcl[r] == 0) begin e_rcd[r] = 1; drops++; end
            end
        end
        for (int p = 0; p < N; p++) begin
            int d;
            d = int'(dv[p*DW +: DW]);
            e_line[p] = 0; e_rec[p] = 0; e_drop[p] = 0;
            if (v[p]) begin
                e_line[p] = try_place(d, used);
                if (e_line[p] == 0) begin
                    if (nr < R) begin e_rec[p] = 1; nrv[nr] = 1; nrd[nr] = d; nr++; end
                    else begin e_drop[p] = 1; drops++; end
                end
            end
        end
        for (int d = 0; d < N; d++) exitmap[(t_now + 1) % TM][d] = 0;
        t_now++;
        for (int r = 0; r < R; r++) begin m_rv[r] = nrv[r]; m_rd[r] = nrd[r]; end
        e_cnt = (e_cnt + drops > 255) ? 255 : e_cnt + drops;
    endtask

    task automatic check(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (slot %0d)", tag, what, act, exp, t_now);
        end
    endtask

    task automatic compare_all();
        for (int p = 0; p < N; p++) begin
            check("R2/R4/R5", $sformatf("gnt_line[%0d]", p), int'(gnt_line[p*LW +: LW]), e_line[p]);
            check("R6", $sformatf("gnt_recirc[%0d]", p), int'(gnt_recirc[p]), int'(e_rec[p]));
            check("R8", $sformatf("gnt_drop[%0d]", p), int'(gnt_drop[p]), int'(e_drop[p]));
        end
        for (int r = 0; r < R; r++) begin
            check("R7", $sformatf("rc_line[%0d]", r), int'(rc_line[r*LW +: LW]), e_rcl[r]);
            check("R7", $sformatf("rc_drop[%0d]", r), int'(rc_drop[r]), int'(e_rcd[r]));
        end
        check("R9", "drop_count", int'(drop_count), e_cnt);
    endtask

    // Called at a negedge; returns at the next negedge after checking.
    task automatic do_slot(input logic [N-1:0] v, input logic [N*DW-1:0] dv);
        req_valid = v;
        req_dest  = dv;
        model_slot(v, dv);
        @(negedge clk);
        compare_all();
    endtask

    task automatic flush();
        for (int k = 0; k < S + 2; k++) do_slot('0, '0);
    endtask

    function automatic logic [N*DW-1:0] dests(int a, int b, int c, int d);
        return {DW'(d), DW'(c), DW'(b), DW'(a)};
    endfunction

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rng;
        model_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "gnt_line", int'(gnt_line), 0);
        check("R1", "gnt_recirc|gnt_drop", int'({gnt_recirc, gnt_drop}), 0);
        check("R1", "rc_line|rc_drop", int'({rc_line, rc_drop}), 0);
        check("R1", "drop_count", int'(drop_count), 0);
        rst_n = 1'b1;

        // R10: idle slot after reset gives nothing
        do_slot('0, '0);

        // R2/R4: four packets to destination 0 take delays 1..4
        do_slot(4'hF, dests(0, 0, 0, 0));
        check("R2", "in0 line", int'(gnt_line[0 +: LW]), 1);
        check("R4", "in3 line", int'(gnt_line[3*LW +: LW]), 4);
        // R4/R6/R8: only delay 4 is free; two recirculate, one drops
        do_slot(4'hF, dests(0, 0, 0, 0));
        check("R4", "in0 line", int'(gnt_line[0 +: LW]), 4);
        check("R6", "recirc flags", int'(gnt_recirc), 4'b0110);
        check("R8", "drop flags", int'(gnt_drop), 4'b1000);
        // R7: returning packets come first; rc0 gets delay 4, rc1 drops
        do_slot('0, '0);
        check("R7", "rc0 line", int'(rc_line[0 +: LW]), 4);
        check("R7", "rc1 drop", int'(rc_drop[1]), 1);
        check("R9", "count after two drops", int'(drop_count), 2);
        flush();

        // R3/R5: distinct destinations, each takes a different line in order
        do_slot(4'hF, dests(0, 1, 2, 3));
        check("R3", "in3 line", int'(gnt_line[3*LW +: LW]), 4);
        flush();

        // Near-exhaustive: every valid pattern and destination combination
        for (int vv = 0; vv < 16; vv++) begin
            for (int dd = 0; dd < 256; dd++) begin
                do_slot(4'(vv), 8'(dd));
                do_slot(4'(vv ^ 4'hA), 8'(dd ^ 8'h5C));
                flush();
            end
        end

        // Random heavy load with back-to-back slots
        rng = 32'h1234_5678;
        for (int k = 0; k < 3000; k++) begin
            rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
            do_slot(rng[3:0] | rng[7:4], rng[15:8] & {4{rng[16], rng[17]}});
        end

        // R9: flood until the counter saturates
        for (int k = 0; k < 120; k++) do_slot(4'hF, dests(1, 1, 1, 1));
        check("R9", "saturated count", int'(drop_count), 255);

        // R1: mid-run reset clears everything
        rst_n = 1'b0;
        @(negedge clk);
        model_reset();
        for (int r = 0; r < R; r++) begin e_rcl[r] = 0; e_rcd[r] = 0; end
        for (int p = 0; p < N; p++) begin e_line[p] = 0; e_rec[p] = 0; e_drop[p] = 0; end
        compare_all();
        rst_n = 1'b1;
        do_slot(4'h1, dests(2, 0, 0, 0));
        check("R1", "fresh line after reset", int'(gnt_line[0 +: LW]), 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule